// File: doc/BRIEF.md
# Oversampled Serial Receiver with Majority Voting

This block is the receive front end of an asynchronous serial port. It watches a raw line input, resynchronises it, and uses an oversampling clock enable from an external rate generator to locate each bit of an incoming frame. The enable runs at 16, 8, 6 or 4 times the bit rate, as chosen by a 2-bit mode input. A falling edge on the idle line opens a frame. A position counter then steps through the sub-bit slots of each bit. Start, data and stop bits are each decided by a two-out-of-three vote over three consecutive samples. At the lowest rate a single sample decides the bit instead.

A start bit that votes high is treated as noise, and the frame is dropped without any output. Eight data bits are collected least significant bit first. One or two stop bits follow, as selected by an input. The receiver reports the word with a single-cycle strobe, and a stop bit that votes low also raises a framing-error flag. The receiver looks for the next start edge as soon as the final stop bit has been decided. It does not wait out the rest of that stop bit, so a transmitter with a slightly fast clock is still received.

Top module: `uart_os_rx`

## Requirements
- R1: With mode 0 (16x), every bit is decided from samples taken at sub-bit positions 8, 9 and 10. Position 1 is the first enable after start detection, and the count wraps to 1 after position 16.
- R2: With mode 1 (8x), every bit is decided from samples at positions 4, 5 and 6 of an 8-position bit.
- R3: With mode 2 (6x), every bit is decided from samples at positions 3, 4 and 5 of a 6-position bit.
- R4: With mode 3 (4x), every bit is decided by one sample at position 3 of a 4-position bit, with no vote.
- R5: In the voting modes, a bit value is 1 when at least two of its three samples are 1. A single disturbed sample leaves the bit unchanged, and three disturbed samples invert it.
- R6: A start bit that decides high cancels the frame. No strobe is produced, and the receiver returns to waiting for a start edge.
- R7: Data bits arrive least significant bit first. `valid_o` is high for exactly one clock per accepted frame, and `data_o` holds the word from that clock on.
- R8: A stop bit that decides low ends the frame with `valid_o` and `frm_err_o` high together. No new start is detected until the synchronised line has been high again.
- R9: After a good final stop bit is decided, a start edge that begins just after the last stop sample position is received as a new frame.
- R10: With `two_stop_i` at 1, two stop bits are each decided. A frame whose second stop bit is low reports a framing error.
- R11: After reset, `valid_o`, `frm_err_o` and `data_o` are all 0.
- R12: `mode_i` and `two_stop_i` are captured when the start edge is detected. Changing them in the middle of a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Raw serial line, idle high |
| tick_i | input | 1 | Oversampling enable, one clock per sub-bit slot |
| mode_i | input | 2 | 0: 16x, 1: 8x, 2: 6x, 3: 4x |
| two_stop_i | input | 1 | 1 selects two stop bits, 0 selects one |
| data_o | output | 8 | Last received word |
| valid_o | output | 1 | One-cycle strobe for a finished frame |
| frm_err_o | output | 1 | Stop-bit error, high only together with valid_o |

## Verification
The case that is hardest to reach is a start edge that arrives inside the nominal stop bit, right after its last sample position. The bench shapes the line slot by slot on enable boundaries and cuts the stop bit down to exactly the sampled slots before it launches the next frame. The same slot-level driver is used to disturb exactly one sample, or all three, of a chosen bit, which checks the vote in both directions. A mode change is also injected in the middle of a frame to confirm that the mode is captured at the start edge.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    OS_X16 = 2'd0,
    OS_X8  = 2'd1,
    OS_X6  = 2'd2,
    OS_X4  = 2'd3
  } os_mode_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RUN  = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_e;

  localparam int POS_W = 5;

  // slots per bit
  function automatic logic [POS_W-1:0] bit_len(os_mode_e m);
    case (m)
      OS_X16:  return POS_W'(16);
      OS_X8:   return POS_W'(8);
      OS_X6:   return POS_W'(6);
      default: return POS_W'(4);
    endcase
  endfunction

  // first sample slot
  function automatic logic [POS_W-1:0] first_pos(os_mode_e m);
    case (m)
      OS_X16:  return POS_W'(8);
      OS_X8:   return POS_W'(4);
      default: return POS_W'(3);
    endcase
  endfunction

  // slot where the bit is decided
  function automatic logic [POS_W-1:0] last_pos(os_mode_e m);
    case (m)
      OS_X16:  return POS_W'(10);
      OS_X8:   return POS_W'(6);
      OS_X6:   return POS_W'(5);
      default: return POS_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/uart_os_sync.sv
module uart_os_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      assign ff_d = d_i;
    end else begin : g_chain
      assign ff_d = {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_os_bitpos.sv
module uart_os_bitpos
  import uart_os_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     run_i,
  input  logic     tick_i,
  input  os_mode_e mode_i,
  output logic     samp_o,
  output logic     dec_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             adv;

  assign adv = run_i & tick_i;

  always_comb begin
    pos_d = pos_q;
    if (clr_i)
      pos_d = '0;
    else if (adv)
      pos_d = (pos_q == bit_len(mode_i)) ? POS_W'(1) : pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign samp_o = adv && (pos_d >= first_pos(mode_i)) && (pos_d <= last_pos(mode_i));
  assign dec_o  = adv && (pos_d == last_pos(mode_i));
endmodule

// File: rtl/uart_os_vote.sv
module uart_os_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_i,
  input  logic single_i,
  input  logic rx_i,
  output logic bit_o
);
  logic [1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (samp_i) hist_d = {hist_q[0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '1;
    else        hist_q <= hist_d;
  end

  // third sample is the live line value in the deciding cycle
  assign bit_o = single_i ? rx_i
               : (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_i) | (hist_q[0] & rx_i);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frm_err_o
);
  localparam int IDX_W      = $clog2(DATA_W + 3);
  localparam int FIRST_STOP = DATA_W + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              rx_s, rx_prev_q;
  logic              start_edge, samp, dec, vbit, run;
  rx_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shr_q, shr_d, data_q, data_d;
  os_mode_e          mode_q, mode_d;
  logic              two_q, two_d, valid_q, valid_d, ferr_q, ferr_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  uart_os_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(rx_i), .q_o(rx_s)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rx_prev_q <= 1'b1;
    else             rx_prev_q <= rx_s;
  end

  assign run        = (st_q == RX_RUN);
  assign start_edge = (st_q == RX_IDLE) && rx_prev_q && !rx_s;

  uart_os_bitpos u_pos (
    .clk(clk), .rst_n(rst_core_n), .clr_i(start_edge), .run_i(run),
    .tick_i(tick_i), .mode_i(mode_q), .samp_o(samp), .dec_o(dec)
  );

  uart_os_vote u_vote (
    .clk(clk), .rst_n(rst_core_n), .samp_i(samp),
    .single_i(mode_q == OS_X4), .rx_i(rx_s), .bit_o(vbit)
  );

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    mode_d  = mode_q;
    two_d   = two_q;
    data_d  = data_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (start_edge) begin
          st_d   = RX_RUN;
          idx_d  = '0;
          mode_d = os_mode_e'(mode_i);
          two_d  = two_stop_i;
        end
      end
      RX_RUN: begin
        if (dec) begin
          if (idx_q == '0) begin
            if (vbit) st_d = RX_IDLE;          // false start
            else      idx_d = idx_q + IDX_W'(1);
          end else if (idx_q <= IDX_W'(DATA_W)) begin
            shr_d = {vbit, shr_q[DATA_W-1:1]};
            idx_d = idx_q + IDX_W'(1);
          end else if (!vbit) begin
            st_d    = RX_HOLD;
            valid_d = 1'b1;
            ferr_d  = 1'b1;
            data_d  = shr_q;
          end else if (two_q && (idx_q == IDX_W'(FIRST_STOP))) begin
            idx_d = idx_q + IDX_W'(1);
          end else begin
            st_d    = RX_IDLE;
            valid_d = 1'b1;
            data_d  = shr_q;
          end
        end
      end
      RX_HOLD: begin
        if (rx_s) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q    <= RX_IDLE;
      idx_q   <= '0;
      shr_q   <= '0;
      mode_q  <= OS_X16;
      two_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      mode_q  <= mode_d;
      two_q   <= two_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign frm_err_o = ferr_q;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic rx_s,
  input logic run,
  input logic samp,
  input logic dec,
  input logic valid_o,
  input logic frm_err_o
);
  AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> tick_i); // R1

  AST_DECIDE_USES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> samp); // R5

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7

  AST_VALID_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(run)); // R7

  AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err_o |-> valid_o); // R8

  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!$past(rx_s) && $past(rx_s, 2))); // R9
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_s(rx_s), .run(run),
  .samp(samp), .dec(dec), .valid_o(valid_o), .frm_err_o(frm_err_o)
);

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       two_stop = 1'b0;
  logic [7:0] data;
  logic       valid, ferr;

  int checks = 0, fails = 0, vcnt = 0, dbl = 0, tdiv = 0;
  logic [7:0] last_d = 8'h00, prev_d = 8'h00;
  logic       last_f = 1'b0, prev_v = 1'b0;

  always #10 clk = ~clk;

  uart_os_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .mode_i(mode),
    .two_stop_i(two_stop), .data_o(data), .valid_o(valid), .frm_err_o(ferr)
  );

  // enable one clock in eight
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 8;
    tick = (tdiv == 0);
  end

  // frame monitor
  always @(negedge clk) begin
    if (valid) begin
      vcnt++;
      prev_d = last_d;
      last_d = data;
      last_f = ferr;
    end
    if (valid && prev_v) dbl++;
    prev_v = valid;
  end

  function automatic int nlen(int m);
    case (m) 0: return 16; 1: return 8; 2: return 6; default: return 4; endcase
  endfunction
  function automatic int fpos(int m);
    case (m) 0: return 8; 1: return 4; default: return 3; endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(bit v);
    @(posedge clk iff tick);
    #1 rx = v;
  endtask

  task automatic idle(int n);
    repeat (n) slot(1'b1);
  endtask

  // slot j of a bit drives the value seen at position j+1
  task automatic send_bit(int m, bit v, int nflip, int nslots);
    for (int j = 0; j < nslots; j++) begin
      bit flip;
      flip = (nflip == 1 && j == fpos(m)) ||
             (nflip == 3 && j >= fpos(m) - 1 && j <= fpos(m) + 1);
      slot(flip ? !v : v);
    end
  endtask

  task automatic send_frame(int m, logic [7:0] d, int nstop, bit bad_stop,
                            int flip_bit, int nflip, int last_len);
    send_bit(m, 1'b0, (flip_bit == 0) ? nflip : 0, nlen(m));
    for (int i = 0; i < 8; i++)
      send_bit(m, d[i], (flip_bit == i + 1) ? nflip : 0, nlen(m));
    for (int s = 0; s < nstop; s++) begin
      bit lst;
      lst = (s == nstop - 1);
      send_bit(m, !(lst && bad_stop), 0, lst ? last_len : nlen(m));
    end
  endtask

  task automatic expect_frame(string tag, int base, logic [7:0] d, bit f);
    chk(vcnt == base + 1, {tag, " frame count"}, vcnt, base + 1);
    chk(last_d == d, {tag, " data"}, last_d, d);
    chk(last_f == f, {tag, " framing flag"}, last_f, f);
  endtask

  task automatic t_reset();
    chk(valid == 1'b0, "R11 valid after reset", valid, 0);
    chk(ferr == 1'b0, "R11 ferr after reset", ferr, 0);
    chk(data == 8'h00, "R11 data after reset", data, 0);
  endtask

  task automatic t_mode(int m, logic [7:0] d, string tag);
    int base;
    mode = m[1:0];
    idle(4);
    base = vcnt;
    send_frame(m, d, 1, 1'b0, -1, 0, nlen(m));
    idle(4);
    expect_frame(tag, base, d, 1'b0);
  endtask

  task automatic t_majority();
    int base;
    mode = 2'd0;
    idle(4);
    base = vcnt;
    send_frame(0, 8'h00, 1, 1'b0, 4, 1, 16);
    idle(4);
    expect_frame("R5 16x one sample disturbed", base, 8'h00, 1'b0);
    base = vcnt;
    send_frame(0, 8'h00, 1, 1'b0, 4, 3, 16);
    idle(4);
    expect_frame("R5 16x three samples disturbed", base, 8'h08, 1'b0);
    base = vcnt;
    send_frame(0, 8'h33, 1, 1'b0, 0, 1, 16);
    idle(4);
    expect_frame("R5 start bit one sample disturbed", base, 8'h33, 1'b0);
    mode = 2'd1;
    idle(4);
    base = vcnt;
    send_frame(1, 8'hFF, 1, 1'b0, 1, 1, 8);
    idle(4);
    expect_frame("R5 8x one sample disturbed", base, 8'hFF, 1'b0);
    base = vcnt;
    send_frame(1, 8'hFF, 1, 1'b0, 1, 3, 8);
    idle(4);
    expect_frame("R5 8x three samples disturbed", base, 8'hFE, 1'b0);
  endtask

  task automatic t_false_start();
    int base;
    mode = 2'd0;
    idle(4);
    base = vcnt;
    slot(1'b0);
    idle(24);
    chk(vcnt == base, "R6 16x glitch gives no frame", vcnt, base);
    mode = 2'd3;
    idle(4);
    slot(1'b0); slot(1'b0);
    idle(12);
    chk(vcnt == base, "R6 4x glitch gives no frame", vcnt, base);
    send_frame(3, 8'h4D, 1, 1'b0, -1, 0, 4);
    idle(4);
    expect_frame("R6 frame after glitch", base, 8'h4D, 1'b0);
  endtask

  task automatic t_ferr();
    int base;
    mode = 2'd1;
    idle(4);
    base = vcnt;
    send_frame(1, 8'hC3, 1, 1'b1, -1, 0, 8);
    repeat (30) slot(1'b0);
    expect_frame("R8 low stop", base, 8'hC3, 1'b1);
    idle(8);
    base = vcnt;
    send_frame(1, 8'h27, 1, 1'b0, -1, 0, 8);
    idle(4);
    expect_frame("R8 recovery frame", base, 8'h27, 1'b0);
  endtask

  task automatic t_rearm(int m, logic [7:0] a, logic [7:0] b, string tag);
    int base;
    mode = m[1:0];
    idle(4);
    base = vcnt;
    send_frame(m, a, 1, 1'b0, -1, 0, fpos(m) + 2);
    send_frame(m, b, 1, 1'b0, -1, 0, nlen(m));
    idle(4);
    chk(vcnt == base + 2, {tag, " frame count"}, vcnt, base + 2);
    chk(prev_d == a, {tag, " first word"}, prev_d, a);
    chk(last_d == b, {tag, " second word"}, last_d, b);
  endtask

  task automatic t_two_stop();
    int base;
    mode = 2'd2;
    two_stop = 1'b1;
    idle(4);
    base = vcnt;
    send_frame(2, 8'h5A, 2, 1'b0, -1, 0, 6);
    idle(4);
    expect_frame("R10 two good stops", base, 8'h5A, 1'b0);
    base = vcnt;
    send_frame(2, 8'hE1, 2, 1'b1, -1, 0, 6);
    idle(8);
    expect_frame("R10 second stop low", base, 8'hE1, 1'b1);
    two_stop = 1'b0;
  endtask

  task automatic t_mode_latch();
    int base;
    mode = 2'd0;
    idle(4);
    base = vcnt;
    fork
      send_frame(0, 8'h96, 1, 1'b0, -1, 0, 16);
      begin
        #(20 * 8 * 24);
        mode = 2'd3;
        two_stop = 1'b1;
      end
    join
    idle(4);
    expect_frame("R12 mode change mid frame", base, 8'h96, 1'b0);
    mode = 2'd0;
    two_stop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode(0, 8'hA5, "R1 16x");
    t_mode(1, 8'h3C, "R2 8x");
    t_mode(2, 8'h81, "R3 6x");
    t_mode(3, 8'h5E, "R4 4x");
    t_majority();
    t_false_start();
    t_ferr();
    t_rearm(0, 8'h6B, 8'h94, "R9 16x early start");
    t_rearm(2, 8'h1F, 8'hC8, "R9 6x early start");
    t_two_stop();
    t_mode_latch();
    chk(dbl == 0, "R7 strobe longer than one clock", dbl, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule